// File: doc/BRIEF.md
# Dual-Channel UART Host Bus Front End

This block links a host processor's parallel register bus to two identical UART channel register files, named A and B. An active-low chip select enables the block. A channel-select input then picks which channel a read or write reaches. The serial engines, baud generators, FIFOs and modem lines are not part of this block. Each channel is represented only by an eight-entry register file, which is the storage those engines would use.

A global broadcast flag lets a single host write update both channels. The flag is bit 0 of the alternate-function register, which sits at register address 2. While the flag is set, every write ignores the channel-select input and stores the data into the addressed register of both channels in the same cycle. Reads are never broadcast: they always come from the channel that channel-select names. Register address 3 holds the line-control setting. Apart from the broadcast flag, every register is plain storage.

Top module: `duart_host_port`

## Requirements
- R1: After reset, every register of both channels reads as zero and the broadcast flag is clear.
- R2: While cs_n is 1, no register of either channel changes, whatever wr_n, addr and wr_data carry.
- R3: With cs_n at 0, chsel at 1 and the broadcast flag clear, a write changes only the addressed register of channel A.
- R4: With cs_n at 0, chsel at 0 and the broadcast flag clear, a write changes only the addressed register of channel B.
- R5: rd_data shows the addressed register of the channel picked by chsel (1 = A, 0 = B) while cs_n and rd_n are both 0. At all other times rd_data is zero.
- R6: While the broadcast flag is set, a write stores wr_data into the addressed register of both channels in the same clock edge, whatever the value of chsel.
- R7: While the broadcast flag is set, reads still follow chsel, so channels A and B can return different data.
- R8: The broadcast flag takes the value of wr_data bit 0 on every accepted write to address 2. This holds for a write to either channel and for a broadcast write. Clearing the flag returns the block to single-channel writes.
- R9: A write is accepted only at a rising clock edge where cs_n and wr_n are both sampled 0. The broadcast flag changes only on an accepted write to address 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| chsel | input | 1 | Channel select: 1 = channel A, 0 = channel B |
| addr | input | 3 | Register address |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, zero when not reading |

## Verification
The bench writes distinct values to every address of each channel, then reads back all sixteen registers. This catches a design that swaps the chsel polarity or writes both channels when only one should change. Writes made with cs_n high and reads made with rd_n high would leave marks in the register files or on rd_data in a design that decodes them wrongly. The broadcast sequence has three steps: set the flag through channel A, write with chsel at 0, then read from both channels. A design that ignores the flag, keeps the flag per channel, or broadcasts reads fails one of these steps. Clearing the flag through a broadcast write, then writing to one channel, shows whether the override really turns off.

// File: rtl/duart_host_pkg.sv
package duart_host_pkg;
  localparam int unsigned CH_B = 0;
  localparam int unsigned CH_A = 1;

  // Per-channel write enables, index = channel code (1 = A, 0 = B).
  function automatic logic [1:0] route_we(input logic cs_n, input logic wr_n,
                                          input logic chsel, input logic bcast);
    logic [1:0] we;
    we = 2'b00;
    if (!cs_n && !wr_n) begin
      if (bcast) we = 2'b11;
      else if (chsel) we = 2'b10;
      else we = 2'b01;
    end
    return we;
  endfunction
endpackage

// File: rtl/duart_bus_decode.sv
module duart_bus_decode #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned AFR_ADDR = 2
) (
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              chsel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bcast_on,
  output logic [1:0]        ch_we,
  output logic              rd_active,
  output logic              afr_write
);
  import duart_host_pkg::*;
  localparam logic [ADDR_W-1:0] AFR_A = ADDR_W'(AFR_ADDR);

  always_comb begin
    ch_we     = route_we(cs_n, wr_n, chsel, bcast_on);
    rd_active = !cs_n && !rd_n;
    afr_write = !cs_n && !wr_n && (addr == AFR_A);
  end
endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] regs [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[i] <= '0;
      else if (we && addr == ADDR_W'(i)) regs[i] <= wdata;
    end
  end

  assign rdata = regs[addr];
endmodule

// File: rtl/duart_bcast_flag.sv
module duart_bcast_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic afr_write,
  input  logic wbit,
  output logic bcast_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcast_on <= 1'b0;
    else if (afr_write) bcast_on <= wbit;
  end
endmodule

// File: rtl/duart_host_port.sv
module duart_host_port #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned AFR_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              chsel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned NCH = 2;

  logic [1:0]        ch_we;
  logic              rd_active;
  logic              afr_write;
  logic              bcast_on;
  logic [DATA_W-1:0] ch_rdata [NCH];

  duart_bus_decode #(.ADDR_W(ADDR_W), .AFR_ADDR(AFR_ADDR)) u_dec (
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .chsel(chsel), .addr(addr),
    .bcast_on(bcast_on), .ch_we(ch_we), .rd_active(rd_active),
    .afr_write(afr_write)
  );

  duart_bcast_flag u_flag (
    .clk(clk), .rst_n(rst_n), .afr_write(afr_write), .wbit(wr_data[0]),
    .bcast_on(bcast_on)
  );

  // Channel index equals the chsel code: 1 = A, 0 = B.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    duart_chan_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(ch_we[c]), .addr(addr),
      .wdata(wr_data), .rdata(ch_rdata[c])
    );
  end

  assign rd_data = rd_active ? ch_rdata[chsel] : '0;
endmodule

// File: rtl/duart_host_port_chk.sv
module duart_host_port_chk #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned AFR_ADDR = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              chsel,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_n,
  input logic              rd_n,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        ch_we,
  input logic              bcast_on
);
  localparam logic [ADDR_W-1:0] AFR_A = ADDR_W'(AFR_ADDR);

  // R2
  deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> ch_we == 2'b00);
  // R3
  chan_a_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && chsel && !bcast_on) |-> ch_we == 2'b10);
  // R4
  chan_b_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && !chsel && !bcast_on) |-> ch_we == 2'b01);
  // R5
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> rd_data == '0);
  // R6
  bcast_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && bcast_on) |-> ch_we == 2'b11);
  // R8
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == AFR_A) |=> bcast_on == $past(wr_data[0]));
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && !wr_n && addr == AFR_A) |=> $stable(bcast_on));
  // R9
  no_strobe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |-> ch_we == 2'b00);
endmodule

bind duart_host_port duart_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .chsel(chsel), .addr(addr),
  .wr_n(wr_n), .rd_n(rd_n), .wr_data(wr_data), .rd_data(rd_data),
  .ch_we(ch_we), .bcast_on(bcast_on)
);

// File: tb/duart_host_port_bench.sv
module duart_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       chsel = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model: index 1 = channel A, 0 = channel B.
  logic [7:0] mdl [2][8];
  bit         mflag = 1'b0;

  always #10 clk = ~clk;

  duart_host_port u_duart_host_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .chsel(chsel), .addr(addr),
    .wr_n(wr_n), .rd_n(rd_n), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input bit cs, input bit ch, input logic [2:0] a,
                           input logic [7:0] d);
    @(negedge clk);
    cs_n = ~cs; chsel = ch; addr = a; wr_data = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    if (cs) begin
      if (mflag) begin mdl[0][a] = d; mdl[1][a] = d; end
      else mdl[ch][a] = d;
      if (a == 3'd2) mflag = d[0];
    end
  endtask

  task automatic bus_read(input bit ch, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; chsel = ch; addr = a;
    #5 d = rd_data;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic verify_all(input string tag);
    logic [7:0] v;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++) begin
        bus_read(c[0], a[2:0], v);
        check(tag, v, mdl[c][a]);
      end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++) mdl[c][a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    verify_all("R1 reset");
    #5 check("R5 idle rd_data", rd_data, 8'h00);

    // R3: fill channel A (skip the flag register)
    for (int a = 0; a < 8; a++)
      if (a != 2) bus_write(1'b1, 1'b1, a[2:0], 8'h10 + 8'(a * 7));
    verify_all("R3 write A only");

    // R4: fill channel B
    for (int a = 0; a < 8; a++)
      if (a != 2) bus_write(1'b1, 1'b0, a[2:0], 8'hC3 ^ 8'(a * 5));
    verify_all("R4 write B only");

    // R2: writes with chip select high change nothing
    for (int a = 0; a < 8; a++) begin
      bus_write(1'b0, 1'b1, a[2:0], 8'hFF);
      bus_write(1'b0, 1'b0, a[2:0], 8'h01);
    end
    verify_all("R2 cs high ignored");

    // R5: read strobe inactive keeps rd_data at zero
    @(negedge clk); cs_n = 1'b0; chsel = 1'b1; addr = 3'd3; rd_n = 1'b1;
    #5 check("R5 rd_n high", rd_data, 8'h00);
    @(negedge clk); cs_n = 1'b1;

    // R9: chip selected, write strobe high: nothing stored
    @(negedge clk); cs_n = 1'b0; chsel = 1'b1; addr = 3'd4; wr_data = 8'h5A;
    @(negedge clk); cs_n = 1'b1;
    verify_all("R9 no strobe");

    // R8: set flag through channel A, then broadcast with chsel = B
    bus_write(1'b1, 1'b1, 3'd2, 8'h01);
    bus_write(1'b1, 1'b0, 3'd3, 8'h3C);
    bus_read(1'b1, 3'd3, v); check("R6 bcast into A", v, 8'h3C);
    bus_read(1'b0, 3'd3, v); check("R6 bcast into B", v, 8'h3C);
    for (int a = 4; a < 8; a++) bus_write(1'b1, a[0], a[2:0], 8'h80 | 8'(a));
    verify_all("R6 bcast sweep");

    // R7: reads follow chsel while broadcasting (address 2 differs per channel)
    bus_read(1'b1, 3'd2, v); check("R7 read A", v, 8'h01);
    bus_read(1'b0, 3'd2, v); check("R7 read B", v, 8'h00);

    // R8: clear flag via broadcast write, then single-channel again
    bus_write(1'b1, 1'b0, 3'd2, 8'hFE);
    bus_write(1'b1, 1'b0, 3'd0, 8'h77);
    bus_read(1'b0, 3'd0, v); check("R8 B after clear", v, 8'h77);
    bus_read(1'b1, 3'd0, v); check("R8 A untouched", v, mdl[1][0]);
    verify_all("R8 after clear");

    // R8: set flag through channel B, broadcast with chsel = A
    bus_write(1'b1, 1'b0, 3'd2, 8'h03);
    bus_write(1'b1, 1'b1, 3'd1, 8'hE1);
    verify_all("R8 set via B");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule